// File: doc/BRIEF.md
# FPU Register High-Half Transfer Unit

This unit carries out the two instructions that move a 32-bit word between a general register and the upper half of a 64-bit floating-point value. It contains its own floating-point register file of 32 entries of 64 bits each. A mode input selects how that file is viewed. In wide mode every entry is a full 64-bit register. In paired mode an even/odd pair of entries holds one 64-bit value, and its upper word sits in the low 32 bits of the odd entry.

Each cycle the pipeline may present one instruction word, together with the low word of the source general register and the FPU-enable state. A move-from instruction returns a sign-extended 64-bit result for the destination general register one cycle later. A move-to instruction updates the register file on the clock edge. If the FPU is disabled, the unit raises a coprocessor-unusable flag and changes nothing. In paired mode an odd register number does not trap. It takes a fixed poison path and raises a warning flag.

Top module: `fhx_top`

## Requirements
- R1: An instruction is acted on only when `valid_i` is high, bits [31:26] are 010001, bits [10:0] are zero, and bits [25:21] are 00011 (move-from) or 00111 (move-to). Bits [20:16] name the destination general register and bits [15:11] name the FP register. Any other word leaves all outputs low and the register file unchanged.
- R2: In wide mode (`fr64_i`=1), a move-from returns bits [63:32] of the selected entry, sign-extended to 64 bits.
- R3: In paired mode with an even register number n, a move-from returns bits [31:0] of entry n+1, sign-extended.
- R4: In paired mode with an odd register number, a move-from returns 64'h000000000BADF00D and raises `poison_o`.
- R5: In wide mode, a move-to writes `rt_word_i` into bits [63:32] of the selected entry and leaves bits [31:0] unchanged.
- R6: In paired mode with an even register number n, a move-to writes `rt_word_i` into bits [31:0] of entry n+1 and leaves its bits [63:32] unchanged.
- R7: In paired mode with an odd register number n, a move-to writes 32'hDEADC0DE into bits [31:0] of entry n and raises `poison_o`.
- R8: A recognised instruction issued with `fpu_en_i` low raises `cpu_unusable_o` for one cycle. It produces no result, no poison flag and no register change.
- R9: After reset, every register entry reads as zero and all outputs are low.
- R10: All outputs are registered and appear in the cycle after the instruction. Only a move-from raises `result_valid_o`, with `dest_o` equal to its bits [20:16]. A move-to is visible to a move-from issued in the very next cycle, and a cycle without `valid_i` leaves all flags low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction present this cycle |
| instr_i | input | 32 | Instruction word |
| rt_word_i | input | 32 | Low word of the source general register |
| fpu_en_i | input | 1 | FPU enabled |
| fr64_i | input | 1 | 1: wide 64-bit registers, 0: paired 32-bit registers |
| result_o | output | 64 | Sign-extended move-from result |
| result_valid_o | output | 1 | `result_o` and `dest_o` are valid |
| dest_o | output | 5 | Destination general register of the result |
| poison_o | output | 1 | Odd-register poison path was taken |
| cpu_unusable_o | output | 1 | Instruction refused because the FPU is disabled |

## Verification
The checker holds the following on every cycle:
- every valid result is a true sign extension of its low word;
- a poisoned read carries exactly the fixed poison constant;
- a poison flag only follows a paired-mode instruction with an odd register number;
- the unusable flag only follows a disabled recognised instruction, and never appears together with a result or a poison flag;
- an idle cycle leaves all flags low in the next cycle.

Which register entry was read or written, preservation of the untouched half, the absence of any write on a refused or unrecognised instruction, and read-after-write across modes all depend on the register contents. Only the bench's scenarios can show these. It does so by writing through one mode and reading back through the other.

// File: rtl/fhx_pkg.sv
package fhx_pkg;
  localparam logic [5:0]  OP_COP1   = 6'b010001;
  localparam logic [4:0]  FMT_FROM  = 5'b00011;
  localparam logic [4:0]  FMT_TO    = 5'b00111;
  localparam logic [31:0] POISON_RD = 32'h0BADF00D;
  localparam logic [31:0] POISON_WR = 32'hDEADC0DE;

  typedef enum logic [1:0] {XF_NONE, XF_FROM, XF_TO} xf_op_e;

  typedef struct packed {
    xf_op_e     op;
    logic [4:0] rt;
    logic [4:0] fs;
  } xf_dec_t;
endpackage

// File: rtl/fhx_decode.sv
module fhx_decode
  import fhx_pkg::*;
(
  input  logic        valid_i,
  input  logic [31:0] instr_i,
  output xf_dec_t     dec_o
);
  logic base_ok;
  assign base_ok = valid_i && (instr_i[31:26] == OP_COP1) && (instr_i[10:0] == '0);

  always_comb begin
    dec_o.rt = instr_i[20:16];
    dec_o.fs = instr_i[15:11];
    dec_o.op = XF_NONE;
    if (base_ok && instr_i[25:21] == FMT_FROM) dec_o.op = XF_FROM;
    if (base_ok && instr_i[25:21] == FMT_TO)   dec_o.op = XF_TO;
  end
endmodule

// File: rtl/fhx_regfile.sv
module fhx_regfile #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned WIDTH    = 64,
  localparam int unsigned AW      = $clog2(NUM_REGS),
  localparam int unsigned HW      = WIDTH / 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [HW-1:0]    wdata_i,
  input  logic [1:0]       whalf_i    // [1]: upper half, [0]: lower half
);
  logic [WIDTH-1:0] mem_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_q[g] <= '0;
      end else if (we_i && waddr_i == AW'(g)) begin
        if (whalf_i[1]) mem_q[g][WIDTH-1:HW] <= wdata_i;
        if (whalf_i[0]) mem_q[g][HW-1:0]     <= wdata_i;
      end
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/fhx_xfer.sv
module fhx_xfer
  import fhx_pkg::*;
#(
  parameter int unsigned WIDTH = 64,
  localparam int unsigned HW   = WIDTH / 2
) (
  input  xf_dec_t          dec_i,
  input  logic             fire_i,
  input  logic             fr64_i,
  input  logic [HW-1:0]    rt_word_i,
  output logic [4:0]       raddr_o,
  input  logic [WIDTH-1:0] rdata_i,
  output logic             we_o,
  output logic [4:0]       waddr_o,
  output logic [HW-1:0]    wdata_o,
  output logic [1:0]       whalf_o,
  output logic [WIDTH-1:0] result_o,
  output logic             poison_o
);
  logic odd_fs, paired_odd;
  logic [HW-1:0] word;

  assign odd_fs     = dec_i.fs[0];
  assign paired_odd = !fr64_i && odd_fs;
  // paired mode: upper word of an even pair lives in the odd partner
  assign raddr_o    = fr64_i ? dec_i.fs : {dec_i.fs[4:1], 1'b1};

  always_comb begin
    if (fr64_i)          word = rdata_i[WIDTH-1:HW];
    else if (paired_odd) word = POISON_RD;
    else                 word = rdata_i[HW-1:0];
  end
  assign result_o = {{HW{word[HW-1]}}, word};
  assign poison_o = fire_i && paired_odd;

  always_comb begin
    we_o    = fire_i && (dec_i.op == XF_TO);
    waddr_o = raddr_o;
    wdata_o = rt_word_i;
    whalf_o = 2'b01;
    if (fr64_i) begin
      whalf_o = 2'b10;
    end else if (paired_odd) begin
      waddr_o = dec_i.fs;
      wdata_o = POISON_WR;
    end
  end
endmodule

// File: rtl/fhx_top.sv
module fhx_top
  import fhx_pkg::*;
#(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned WIDTH    = 64,
  localparam int unsigned HW      = WIDTH / 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [31:0]      instr_i,
  input  logic [HW-1:0]    rt_word_i,
  input  logic             fpu_en_i,
  input  logic             fr64_i,
  output logic [WIDTH-1:0] result_o,
  output logic             result_valid_o,
  output logic [4:0]       dest_o,
  output logic             poison_o,
  output logic             cpu_unusable_o
);
  xf_dec_t          dec;
  logic             known, fire;
  logic [4:0]       raddr, waddr;
  logic [WIDTH-1:0] rdata, res_d;
  logic             we, pois_d;
  logic [HW-1:0]    wdata;
  logic [1:0]       whalf;

  fhx_decode u_dec (.valid_i(valid_i), .instr_i(instr_i), .dec_o(dec));

  assign known = (dec.op != XF_NONE);
  assign fire  = known && fpu_en_i;

  fhx_xfer #(.WIDTH(WIDTH)) u_xfer (
    .dec_i(dec), .fire_i(fire), .fr64_i(fr64_i), .rt_word_i(rt_word_i),
    .raddr_o(raddr), .rdata_i(rdata), .we_o(we), .waddr_o(waddr),
    .wdata_o(wdata), .whalf_o(whalf), .result_o(res_d), .poison_o(pois_d)
  );

  fhx_regfile #(.NUM_REGS(NUM_REGS), .WIDTH(WIDTH)) u_rf (
    .clk_i(clk_i), .rst_ni(rst_ni), .raddr_i(raddr), .rdata_o(rdata),
    .we_i(we), .waddr_i(waddr), .wdata_i(wdata), .whalf_i(whalf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o       <= '0;
      result_valid_o <= 1'b0;
      dest_o         <= '0;
      poison_o       <= 1'b0;
      cpu_unusable_o <= 1'b0;
    end else begin
      result_valid_o <= fire && (dec.op == XF_FROM);
      poison_o       <= pois_d;
      cpu_unusable_o <= known && !fpu_en_i;
      if (fire && dec.op == XF_FROM) begin
        result_o <= res_d;
        dest_o   <= dec.rt;
      end
    end
  end
endmodule

// File: rtl/fhx_checker.sv
module fhx_checker #(
  parameter int unsigned WIDTH = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [31:0]      instr_i,
  input logic             fpu_en_i,
  input logic             fr64_i,
  input logic [WIDTH-1:0] result_o,
  input logic             result_valid_o,
  input logic             poison_o,
  input logic             cpu_unusable_o
);
  localparam int unsigned HW = WIDTH / 2;

  p_sext_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |-> result_o[WIDTH-1:HW] == {HW{result_o[HW-1]}});

  p_poison_value_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_valid_o && poison_o) |-> result_o == WIDTH'(32'h0BADF00D));

  p_poison_odd_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (fr64_i || !instr_i[11])) |=> !poison_o);

  p_unusable_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_unusable_o |-> (!result_valid_o && !poison_o));

  p_enabled_no_unusable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && fpu_en_i) |=> !cpu_unusable_o);

  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!result_valid_o && !poison_o && !cpu_unusable_o));
endmodule

bind fhx_top fhx_checker #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/fhx_top_tb.sv
module fhx_top_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic [31:0] rt_word_i = '0;
  logic        fpu_en_i = 1'b0;
  logic        fr64_i = 1'b0;
  logic [63:0] result_o;
  logic        result_valid_o;
  logic [4:0]  dest_o;
  logic        poison_o;
  logic        cpu_unusable_o;

  always #2.5 clk_i = ~clk_i;

  fhx_top u_dut (.*);

  typedef struct {
    logic        rv;
    logic        unus;
    logic        pois;
    logic [63:0] data;
    logic [4:0]  dest;
    string       tag;
  } exp_t;

  exp_t        exp_q[$];
  logic [63:0] mdl [32];
  int          n_cmp = 0, n_bad = 0;
  bit          done = 1'b0;

  function automatic logic [63:0] sx(input logic [31:0] w);
    return {{32{w[31]}}, w};
  endfunction

  task automatic issue(input logic vld, input logic en, input logic f64,
                       input logic [4:0] fmt, input logic [4:0] rt,
                       input logic [4:0] fs, input logic [10:0] tail,
                       input logic [31:0] gw, input string tag);
    exp_t e;
    logic op;
    @(negedge clk_i);
    valid_i = vld; fpu_en_i = en; fr64_i = f64; rt_word_i = gw;
    instr_i = {6'b010001, fmt, rt, fs, tail};
    e = '{rv: 1'b0, unus: 1'b0, pois: 1'b0, data: '0, dest: rt, tag: tag};
    op = vld && tail == '0 && (fmt == 5'b00011 || fmt == 5'b00111);
    if (op && !en) begin
      e.unus = 1'b1;
    end else if (op && fmt == 5'b00011) begin
      e.rv = 1'b1;
      if (f64)        e.data = sx(mdl[fs][63:32]);
      else if (!fs[0]) e.data = sx(mdl[fs | 5'd1][31:0]);
      else begin e.data = sx(32'h0BADF00D); e.pois = 1'b1; end
    end else if (op) begin
      if (f64)        mdl[fs][63:32] = gw;
      else if (!fs[0]) mdl[fs | 5'd1][31:0] = gw;
      else begin mdl[fs][31:0] = 32'hDEADC0DE; e.pois = 1'b1; end
    end
    exp_q.push_back(e);
  endtask

  task automatic rd(input logic f64, input logic [4:0] fs, input string tag);
    issue(1'b1, 1'b1, f64, 5'b00011, 5'd9, fs, 11'd0, 32'h0, tag);
  endtask

  task automatic wr(input logic f64, input logic [4:0] fs, input logic [31:0] w,
                    input string tag);
    issue(1'b1, 1'b1, f64, 5'b00111, 5'd0, fs, 11'd0, w, tag);
  endtask

  // monitor: one expected item per issued cycle, sampled after the edge
  initial begin
    forever begin
      @(posedge clk_i); #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_cmp++;
        if (result_valid_o !== e.rv || cpu_unusable_o !== e.unus || poison_o !== e.pois ||
            (e.rv && (result_o !== e.data || dest_o !== e.dest))) begin
          n_bad++;
          $display("FAIL %s: rv=%b unus=%b pois=%b data=%h dest=%0d expected rv=%b unus=%b pois=%b data=%h dest=%0d",
                   e.tag, result_valid_o, cpu_unusable_o, poison_o, result_o, dest_o,
                   e.rv, e.unus, e.pois, e.data, e.dest);
        end
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) mdl[i] = '0;
    repeat (3) @(negedge clk_i);
    n_cmp++;  // R9 reset outputs
    if (result_valid_o !== 1'b0 || poison_o !== 1'b0 || cpu_unusable_o !== 1'b0 || result_o !== '0) begin
      n_bad++;
      $display("FAIL R9: outputs rv=%b pois=%b unus=%b data=%h expected all zero",
               result_valid_o, poison_o, cpu_unusable_o, result_o);
    end
    rst_ni = 1'b1;

    rd(1'b1, 5'd0, "R9");
    rd(1'b0, 5'd30, "R9");
    wr(1'b1, 5'd5, 32'h89ABCDEF, "R5");
    rd(1'b1, 5'd5, "R2");
    wr(1'b0, 5'd4, 32'h12345678, "R6");
    rd(1'b0, 5'd4, "R3");
    rd(1'b1, 5'd5, "R6");
    wr(1'b1, 5'd5, 32'h70000001, "R5");
    rd(1'b0, 5'd4, "R5");
    rd(1'b1, 5'd5, "R10");
    wr(1'b0, 5'd7, 32'h11111111, "R7");
    rd(1'b0, 5'd6, "R7");
    rd(1'b1, 5'd7, "R7");
    rd(1'b0, 5'd3, "R4");
    issue(1'b1, 1'b0, 1'b1, 5'b00111, 5'd0, 5'd5, 11'd0, 32'hAAAAAAAA, "R8");
    rd(1'b1, 5'd5, "R8");
    issue(1'b1, 1'b0, 1'b0, 5'b00011, 5'd3, 5'd4, 11'd0, 32'h0, "R8");
    rd(1'b0, 5'd4, "R8");
    issue(1'b1, 1'b1, 1'b1, 5'b00111, 5'd0, 5'd5, 11'd1, 32'h55555555, "R1");
    issue(1'b1, 1'b1, 1'b1, 5'b00100, 5'd0, 5'd5, 11'd0, 32'h55555555, "R1");
    issue(1'b0, 1'b1, 1'b1, 5'b00111, 5'd0, 5'd5, 11'd0, 32'h55555555, "R10");
    rd(1'b1, 5'd5, "R1");
    wr(1'b0, 5'd30, 32'h80000000, "R6");
    issue(1'b1, 1'b1, 1'b0, 5'b00011, 5'd31, 5'd30, 11'd0, 32'h0, "R10");
    wr(1'b1, 5'd31, 32'h00000042, "R5");
    rd(1'b0, 5'd30, "R5");
    rd(1'b1, 5'd31, "R2");
    issue(1'b0, 1'b0, 1'b0, 5'b00000, 5'd0, 5'd0, 11'd0, 32'h0, "R10");
    repeat (3) @(negedge clk_i);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule